// File: doc/BRIEF.md
# Dual-Bank Latch with Output Multiplexer

The block stores two words, one from bus A and one from bus B, in two banks that share a single active-low latch control. A select input picks which bank drives the output word. The output path is modelled as a data word plus a drive-enable bit.

While the latch control is Low, both banks follow their inputs and the output is released. Its data is held at zero and its drive-enable is deasserted. When the control returns High, both banks freeze together and the output drives the chosen bank. The select acts combinationally on the output path. Toggling it while the banks hold switches between the two stored words and reloads neither bank.

The latch control is sampled on the system clock, which makes the block synchronous. Any bank update, and any change of the drive-enable, takes effect at a rising clock edge.

Top module: `dual_bank_latch_mux`

## Requirements
- R1: While reset (rst_ni Low) is asserted, both banks are cleared to zero, q_o is zero and q_oe_o is 0. The output stays disabled until a clock edge samples le_ni High.
- R2: After each rising edge, q_oe_o equals the level of le_ni sampled at that edge. The value 1 means the output is driven.
- R3: While q_oe_o is 0, q_o reads all zeros.
- R4: At each rising edge where le_ni is Low, bank A loads a_i and bank B loads b_i at the same edge.
- R5: At each rising edge where le_ni is High, both banks keep their stored words.
- R6: While q_oe_o is 1, sel_a_i=1 routes bank A to q_o and sel_a_i=0 routes bank B. The routing follows sel_a_i in the same cycle, with no clock edge needed.
- R7: Changes on a_i and b_i that are sampled only at edges where le_ni is High have no effect on either stored word.
- R8: Toggling sel_a_i while the banks hold changes neither stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | WIDTH | Data for bank A |
| b_i | input | WIDTH | Data for bank B |
| sel_a_i | input | 1 | 1 selects bank A, 0 selects bank B |
| le_ni | input | 1 | Active-low latch control, sampled on clk_i |
| q_o | output | WIDTH | Output data, zero while not driven |
| q_oe_o | output | 1 | Output drive-enable |

## Verification
Bank contents and q_oe_o are due one clock edge after le_ni, a_i and b_i are sampled. The bench drives these inputs on the falling edge. It updates its reference banks from the same values at the rising edge, and it compares the outputs shortly after that edge. The select path has zero cycles of latency. Its checks change sel_a_i away from any clock edge and compare a moment later, before the next rising edge arrives.

// File: rtl/dblm_pkg.sv
package dblm_pkg;
  localparam int unsigned DEF_WIDTH = 8;
  localparam int unsigned NUM_BANKS = 2;
  // bank index order is fixed: index 1 is A, index 0 is B
  typedef enum logic {BANK_B = 1'b0, BANK_A = 1'b1} bank_e;
endpackage

// File: rtl/dblm_le_sync.sv
module dblm_le_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic le_ni,
  output logic load_o,
  output logic drive_o
);
  logic le_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) le_q <= 1'b0;
    else         le_q <= le_ni;
  end

  assign load_o  = ~le_ni;
  assign drive_o = le_q;

  // R2
  oe_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_ni |=> drive_o);
  // R2
  oe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !le_ni |=> !drive_o);
endmodule

// File: rtl/dblm_bank.sv
module dblm_bank #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  // R4
  bank_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o == $past(d_i));
  // R5
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/dblm_out_mux.sv
module dblm_out_mux #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             sel_a_i,
  input  logic             drive_i,
  input  logic [WIDTH-1:0] bank_a_i,
  input  logic [WIDTH-1:0] bank_b_i,
  output logic [WIDTH-1:0] q_o
);
  import dblm_pkg::*;
  bank_e sel;

  assign sel = bank_e'(sel_a_i);

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
    always_comb begin
      if (!drive_i)          q_o[gi] = 1'b0;
      else if (sel == BANK_A) q_o[gi] = bank_a_i[gi];
      else                   q_o[gi] = bank_b_i[gi];
    end
  end
endmodule

// File: rtl/dual_bank_latch_mux.sv
module dual_bank_latch_mux #(
  parameter int unsigned WIDTH = dblm_pkg::DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sel_a_i,
  input  logic             le_ni,
  output logic [WIDTH-1:0] q_o,
  output logic             q_oe_o
);
  import dblm_pkg::*;

  logic                             load;
  logic                             drive;
  logic [NUM_BANKS-1:0][WIDTH-1:0]  bank_d;
  logic [NUM_BANKS-1:0][WIDTH-1:0]  bank_q;

  assign bank_d[BANK_A] = a_i;
  assign bank_d[BANK_B] = b_i;

  dblm_le_sync u_le_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .le_ni   (le_ni),
    .load_o  (load),
    .drive_o (drive)
  );

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    dblm_bank #(.WIDTH(WIDTH)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .d_i    (bank_d[gb]),
      .q_o    (bank_q[gb])
    );
  end

  dblm_out_mux #(.WIDTH(WIDTH)) u_mux (
    .sel_a_i  (sel_a_i),
    .drive_i  (drive),
    .bank_a_i (bank_q[BANK_A]),
    .bank_b_i (bank_q[BANK_B]),
    .q_o      (q_o)
  );

  assign q_oe_o = drive;

  // R3
  float_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !le_ni |=> q_o == '0);
  // R6
  route_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_oe_o && sel_a_i) |-> q_o == bank_q[BANK_A]);
  // R6
  route_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_oe_o && !sel_a_i) |-> q_o == bank_q[BANK_B]);
endmodule

// File: tb/dual_bank_latch_mux_tb.sv
module dual_bank_latch_mux_tb;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         sel_a_i = 1'b0, le_ni = 1'b1;
  logic [W-1:0] q_o;
  logic         q_oe_o;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] m_a = '0, m_b = '0;
  logic         m_oe = 1'b0;
  int unsigned  seed = 32'h5eed_1234;

  always #10 clk_i = ~clk_i;

  dual_bank_latch_mux #(.WIDTH(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i),
    .sel_a_i(sel_a_i), .le_ni(le_ni), .q_o(q_o), .q_oe_o(q_oe_o)
  );

  function automatic logic [W-1:0] exp_q(logic oe, logic s, logic [W-1:0] ba, logic [W-1:0] bb);
    if (!oe) return '0;
    return s ? ba : bb;
  endfunction

  task automatic check(string req);
    logic [W-1:0] eq;
    eq = exp_q(m_oe, sel_a_i, m_a, m_b);
    n_chk++;
    if (q_oe_o !== m_oe || q_o !== eq) begin
      n_fail++;
      $display("FAIL %s: q_o=%h q_oe_o=%b expected q_o=%h q_oe_o=%b", req, q_o, q_oe_o, eq, m_oe);
    end
  endtask

  // one clock: inputs already stable since the falling edge
  task automatic tick(string req);
    @(posedge clk_i);
    if (!le_ni) begin m_a = a_i; m_b = b_i; end
    m_oe = le_ni;
    #2;
    check(req);
    @(negedge clk_i);
  endtask

  task automatic flip_sel(string req);
    sel_a_i = ~sel_a_i;
    #1;
    check(req);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    // R1: reset state
    a_i = 8'hA5; b_i = 8'h5A; le_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 during reset");
    le_ni = 1'b1;
    rst_ni = 1'b1;
    @(negedge clk_i);
    tick("R1 first driven edge shows cleared banks");
    flip_sel("R1 other bank cleared");

    // R4: load both banks together, output floats
    le_ni = 1'b0; a_i = 8'h3C; b_i = 8'hC3;
    tick("R3 outputs zero while open");
    a_i = 8'h11; b_i = 8'h22;
    tick("R4 banks follow inputs");
    le_ni = 1'b1; a_i = 8'h99; b_i = 8'h77;
    tick("R5 close edge holds last open value");
    flip_sel("R6 select switch");
    flip_sel("R8 select back");
    // R7: input changes while holding
    for (int i = 0; i < 6; i++) begin
      a_i = W'($urandom); b_i = W'($urandom);
      tick("R7 inputs ignored while holding");
      flip_sel("R8 no reload on select");
    end
    // R2: enable toggling each cycle
    for (int i = 0; i < 8; i++) begin
      le_ni = ~le_ni; a_i = W'($urandom); b_i = W'($urandom);
      tick("R2 drive enable follows sampled control");
    end
    // random phase
    for (int i = 0; i < 2000; i++) begin
      le_ni = ($urandom % 3) != 0;
      a_i = W'($urandom); b_i = W'($urandom);
      sel_a_i = $urandom % 2;
      tick(le_ni ? "R6 random hold" : "R4 random load");
      if ($urandom % 2) flip_sel(m_oe ? "R8 random select" : "R3 random select while open");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule